// File: doc/BRIEF.md
# Threshold-Based Interrupt Status Unit

This unit gathers the interrupt causes of a serial peripheral controller into one seven-bit status word and drives a single level-sensitive interrupt line. Three causes are events: transmit underflow, receive overflow and mode fault. Each one arrives as a one-cycle pulse and is latched until software acknowledges it. The other four causes are levels that are recomputed every cycle from the state of the transmit and receive FIFOs. Two of them are the plain full flags. The other two compare the FIFO occupancy against thresholds that software can program.

Software reaches the unit through a small register port: one write strobe with an address and write data, and a read data bus that decodes the address combinationally. Masking is done through separate set and clear addresses, so one write can change some mask bits without a read-modify-write. The interrupt line is registered. It reflects the masked status word one clock after any change to the status or the mask. All pins are plain control and status signals. None of them carries a data stream, so the unit has no valid/ready handshake.

Top module: `threshold_irq_unit`

## Requirements
- R1: After reset the latched event bits and the mask are all 0, both thresholds read back as 1, and `irq` is low.
- R2: The status word, read at address 0x04, has bit 0 = RX overflow, bit 1 = mode fault, bit 2 = TX below threshold, bit 3 = TX full, bit 4 = RX at/above threshold, bit 5 = RX full, bit 6 = TX underflow.
- R3: A pulse on `ev_rx_overflow`, `ev_mode_fail` or `ev_tx_underflow` sets status bit 0, 1 or 6 at the next edge. The bit stays set until a write to 0x04 with a 1 in that bit position. Zero bits in that write leave the bit unchanged.
- R4: When an event pulse and a clearing write to the same bit arrive in the same cycle, the bit is set after the edge.
- R5: Status bit 4 equals (`rx_count` >= RX threshold). Status bit 2 equals (`tx_count` < TX threshold). Both are evaluated on the current inputs.
- R6: Status bit 5 equals `rx_full` and status bit 3 equals `tx_full`, on the current inputs.
- R7: A write to 0x08 ORs `reg_wdata[6:0]` into the mask. A write to 0x0C clears every mask bit that has a 1 in `reg_wdata[6:0]`. The mask reads at 0x10, and writes to 0x10 are ignored. Addresses 0x08 and 0x0C read as 0.
- R8: A write to 0x28 (TX threshold) or 0x2C (RX threshold) stores the low CW bits of `reg_wdata`. Each threshold reads back zero-extended from its address.
- R9: At every edge `irq` takes the value of (mask AND status) != 0, computed from the values present before that edge.
- R10: Status and mask read with bits 31:7 at 0. Every other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_count | input | CW | TX FIFO occupancy |
| tx_full | input | 1 | TX FIFO full flag |
| rx_count | input | CW | RX FIFO occupancy |
| rx_full | input | 1 | RX FIFO full flag |
| ev_tx_underflow | input | 1 | One-cycle TX underflow event |
| ev_rx_overflow | input | 1 | One-cycle RX overflow event |
| ev_mode_fail | input | 1 | One-cycle mode fault event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the unit with a FIFO depth of 8, which gives CW = 4. With that setting the counts reach the full value and beyond-depth thresholds (up to 15) in a few cycles. Every comparison edge is therefore exercised: threshold 0, threshold equal to the count, threshold equal to the depth, and thresholds that can never be met. Random phases mix events, clearing writes, mask updates and threshold writes on the same cycles. This drives the event-versus-clear collision and the mask-to-interrupt latency many times.

// File: rtl/thirq_pkg.sv
package thirq_pkg;
  localparam int NBITS = 7;

  localparam int B_RX_OVF  = 0;
  localparam int B_MODE    = 1;
  localparam int B_TX_LOW  = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_HIGH = 4;
  localparam int B_RX_FULL = 5;
  localparam int B_TX_UNF  = 6;

  localparam int NSTICKY = 3;

  localparam int A_STATUS = 'h04;
  localparam int A_MSET   = 'h08;
  localparam int A_MCLR   = 'h0C;
  localparam int A_MASK   = 'h10;
  localparam int A_TXTHR  = 'h28;
  localparam int A_RXTHR  = 'h2C;

  typedef logic [NBITS-1:0] stat_t;

  function automatic int sticky_pos(input int i);
    case (i)
      0:       return B_RX_OVF;
      1:       return B_MODE;
      default: return B_TX_UNF;
    endcase
  endfunction
endpackage

// File: rtl/irq_level_eval.sv
module irq_level_eval
  import thirq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_thr,
  input  logic [CW-1:0] rx_thr,
  input  logic          tx_full,
  input  logic          rx_full,
  output stat_t         level_bits
);
  always_comb begin
    level_bits            = '0;
    level_bits[B_TX_LOW]  = (tx_count < tx_thr);
    level_bits[B_RX_HIGH] = (rx_count >= rx_thr);
    level_bits[B_TX_FULL] = tx_full;
    level_bits[B_RX_FULL] = rx_full;
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import thirq_pkg::*;
#(
  parameter int CW     = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output stat_t             mask_q,
  output logic [CW-1:0]     tx_thr,
  output logic [CW-1:0]     rx_thr,
  output stat_t             w1c
);
  logic hit_set, hit_clr, hit_txt, hit_rxt, hit_stat;
  stat_t wbits;

  assign wbits    = reg_wdata[NBITS-1:0];
  assign hit_set  = reg_wr && (reg_addr == ADDR_W'(A_MSET));
  assign hit_clr  = reg_wr && (reg_addr == ADDR_W'(A_MCLR));
  assign hit_txt  = reg_wr && (reg_addr == ADDR_W'(A_TXTHR));
  assign hit_rxt  = reg_wr && (reg_addr == ADDR_W'(A_RXTHR));
  assign hit_stat = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
  assign w1c      = hit_stat ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      tx_thr <= CW'(1);
      rx_thr <= CW'(1);
    end else begin
      if (hit_set)      mask_q <= mask_q | wbits;
      else if (hit_clr) mask_q <= mask_q & ~wbits;
      if (hit_txt) tx_thr <= reg_wdata[CW-1:0];
      if (hit_rxt) rx_thr <= reg_wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/threshold_irq_unit.sv
module threshold_irq_unit
  import thirq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     tx_count,
  input  logic              tx_full,
  input  logic [CW-1:0]     rx_count,
  input  logic              rx_full,
  input  logic              ev_tx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fail,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  stat_t mask_q, w1c, level_bits, status_vec;
  logic [CW-1:0] tx_thr, rx_thr;
  logic [NSTICKY-1:0] ev_vec, clr_vec, sticky_q;

  irq_ctrl_regs #(.CW(CW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mask_q(mask_q), .tx_thr(tx_thr),
    .rx_thr(rx_thr), .w1c(w1c)
  );

  irq_level_eval #(.CW(CW)) u_level (
    .tx_count(tx_count), .rx_count(rx_count), .tx_thr(tx_thr),
    .rx_thr(rx_thr), .tx_full(tx_full), .rx_full(rx_full),
    .level_bits(level_bits)
  );

  assign ev_vec = {ev_tx_underflow, ev_mode_fail, ev_rx_overflow};

  for (genvar i = 0; i < NSTICKY; i++) begin : g_clr
    assign clr_vec[i] = w1c[sticky_pos(i)];
  end

  irq_sticky_bank #(.N(NSTICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(clr_vec), .q(sticky_q)
  );

  always_comb begin
    status_vec = level_bits;
    for (int i = 0; i < NSTICKY; i++) status_vec[sticky_pos(i)] = sticky_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(mask_q & status_vec);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_STATUS))     reg_rdata[NBITS-1:0] = status_vec;
    else if (reg_addr == ADDR_W'(A_MASK))  reg_rdata[NBITS-1:0] = mask_q;
    else if (reg_addr == ADDR_W'(A_TXTHR)) reg_rdata[CW-1:0]    = tx_thr;
    else if (reg_addr == ADDR_W'(A_RXTHR)) reg_rdata[CW-1:0]    = rx_thr;
  end
endmodule

// File: rtl/threshold_irq_unit_chk.sv
module threshold_irq_unit_chk
  import thirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ev_rx_overflow,
  input logic              ev_mode_fail,
  input logic              ev_tx_underflow,
  input logic              rx_full,
  input logic              tx_full,
  input logic              irq,
  input stat_t             status_vec,
  input stat_t             mask_q
);
  logic wr_stat, wr_set, wr_clr;
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
  assign wr_set  = reg_wr && (reg_addr == ADDR_W'(A_MSET));
  assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(A_MCLR));

  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |=> status_vec[B_RX_OVF]);
  assert_unf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_underflow && wr_stat && reg_wdata[B_TX_UNF]) |=> status_vec[B_TX_UNF]);
  assert_mode_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vec[B_MODE] && !(wr_stat && reg_wdata[B_MODE])) |=> status_vec[B_MODE]);
  assert_mode_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[B_MODE] && !ev_mode_fail) |=> !status_vec[B_MODE]);
  assert_full_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vec[B_RX_FULL] == rx_full) && (status_vec[B_TX_FULL] == tx_full));
  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(reg_wdata[NBITS-1:0])) == $past(reg_wdata[NBITS-1:0])));
  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(reg_wdata[NBITS-1:0])) == '0));
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
endmodule

bind threshold_irq_unit threshold_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/threshold_irq_unit_tb.sv
`timescale 1ns/1ps
module threshold_irq_unit_tb;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] tx_count = 0, rx_count = 0;
  logic tx_full = 0, rx_full = 0;
  logic ev_tx_underflow = 0, ev_rx_overflow = 0, ev_mode_fail = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  int m_st = 0, m_mask = 0, m_ttx = 1, m_trx = 1;
  bit m_irq = 0;

  always #2.5 clk = ~clk;

  threshold_irq_unit #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status();
    int s = m_st;
    if (rx_full)                   s |= 32'h20;
    if (int'(rx_count) >= m_trx)   s |= 32'h10;
    if (tx_full)                   s |= 32'h08;
    if (int'(tx_count) < m_ttx)    s |= 32'h04;
    return s;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      'h04: return exp_status();
      'h10: return m_mask;
      'h28: return m_ttx;
      'h2C: return m_trx;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      'h04: return "R2 R3 R5 R6";
      'h08, 'h0C, 'h10: return "R7";
      'h28, 'h2C: return "R8";
      default: return "R10";
    endcase
  endfunction

  // evs: bit0 rx overflow, bit1 mode fault, bit2 tx underflow
  task automatic step(input bit wr, input int a, input int wd, input int evs,
                      input int txc, input int rxc, input string tag);
    int e, clr;
    @(negedge clk);
    chk(irq == m_irq, "R9 irq", int'(irq), int'(m_irq));
    reg_wr = wr; reg_addr = 8'(a); reg_wdata = wd;
    ev_rx_overflow = evs[0]; ev_mode_fail = evs[1]; ev_tx_underflow = evs[2];
    tx_count = CW'(txc); rx_count = CW'(rxc);
    tx_full = (txc == DEPTH); rx_full = (rxc == DEPTH);
    #1;
    e = exp_read(a);
    chk(reg_rdata == 32'(e), (tag == "") ? tag_of(a) : tag, int'(reg_rdata), e);
    m_irq = (m_mask & exp_status()) != 0;
    clr = (wr && a == 'h04) ? (wd & 'h43) : 0;
    m_st = (m_st & ~clr) | (evs[0] ? 1 : 0) | (evs[1] ? 2 : 0) | (evs[2] ? 'h40 : 0);
    if (wr && a == 'h08) m_mask |= (wd & 'h7F);
    if (wr && a == 'h0C) m_mask &= ~(wd & 'h7F);
    if (wr && a == 'h28) m_ttx = wd & ((1 << CW) - 1);
    if (wr && a == 'h2C) m_trx = wd & ((1 << CW) - 1);
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 0, "R1 irq in reset", int'(irq), 0);
    rst_n = 1;
    // R1 reset state readback
    step(0, 'h28, 0, 0, 0, 0, "R1");
    step(0, 'h2C, 0, 0, 0, 0, "R1");
    step(0, 'h10, 0, 0, 0, 0, "R1");
    step(0, 'h04, 0, 0, 0, 0, "R1 R2");
    // R3 each event latches, zero bits do not clear
    step(0, 'h04, 0, 1, 0, 0, "R3");
    step(0, 'h04, 0, 2, 0, 0, "R3");
    step(0, 'h04, 0, 4, 0, 0, "R3");
    step(1, 'h04, 'h3C, 0, 0, 0, "R3");
    step(1, 'h04, 'h02, 0, 0, 0, "R3");
    step(0, 'h04, 0, 0, 0, 0, "R3");
    // R4 collision: event and clear same cycle
    step(1, 'h04, 'h41, 4, 0, 0, "R4");
    step(0, 'h04, 0, 0, 0, 0, "R4");
    chk(reg_rdata[6] == 1'b1, "R4 event wins", int'(reg_rdata[6]), 1);
    chk(reg_rdata[0] == 1'b0, "R4 other bit cleared", int'(reg_rdata[0]), 0);
    step(1, 'h04, 'h7F, 0, 0, 0, "R3");
    // R5 threshold sweeps
    step(1, 'h2C, 3, 0, 0, 0, "R8");
    step(1, 'h28, 5, 0, 0, 0, "R8");
    for (int c = 0; c <= DEPTH; c++) step(0, 'h04, 0, 0, c, c, "R5 R6");
    step(1, 'h2C, 0, 0, 0, 0, "R8");
    step(1, 'h28, 'hFFF0, 0, 0, 0, "R8");
    for (int c = 0; c <= DEPTH; c++) step(0, 'h04, 0, 0, c, DEPTH - c, "R5 R6");
    // R7/R9 masking
    step(1, 'h10, 'h7F, 0, 0, 0, "R7");
    step(0, 'h10, 0, 0, 0, 0, "R7");
    step(1, 'h08, 'h21, 0, 0, 0, "R7");
    step(0, 'h08, 0, 1, 0, 0, "R7");
    step(0, 'h0C, 0, 0, 0, 0, "R7");
    step(1, 'h0C, 'h01, 0, 0, DEPTH, "R7 R9");
    step(0, 'h10, 0, 0, 0, DEPTH, "R9");
    step(0, 'h10, 0, 0, 0, 0, "R9");
    // R10 other addresses
    step(0, 'h00, 0, 0, 0, 0, "R10");
    step(0, 'h14, 0, 0, 0, 0, "R10");
    step(0, 'hFC, 0, 0, 0, 0, "R10");
    // random mix
    for (int k = 0; k < 6000; k++) begin
      int sel, a, wd;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    a = 'h04;
        2:       a = 'h08;
        3:       a = 'h0C;
        4:       a = 'h10;
        5:       a = 'h28;
        6:       a = 'h2C;
        7:       a = 'h04;
        8:       a = 'h10;
        default: a = $urandom_range(0, 255);
      endcase
      wd = $urandom;
      if (a == 'h28 || a == 'h2C) wd = $urandom_range(0, DEPTH + 2);
      step($urandom_range(0, 2) == 0, a, wd, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 0,
           $urandom_range(0, DEPTH), $urandom_range(0, DEPTH), "");
    end
    @(negedge clk);
    chk(irq == m_irq, "R9 irq", int'(irq), int'(m_irq));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule